// File: doc/BRIEF.md
# Clock Synthesizer Configuration Latch

This block holds the configuration word of a frequency synthesizer. The word has three fields: a 9-bit feedback divider value, a 2-bit output divider select and a 3-bit test-output select. Software or board logic can load it in two ways. The first is a three-wire serial port made of a serial clock, serial data and a serial load strobe. The second is a set of parallel divider pins with a parallel load strobe.

All pins are sampled by the block clock through two-flop synchronizers. A serial bit is taken on each rising edge of the serial clock, after that edge has been detected at the block clock. The serial clock must therefore stay at or below 10 MHz, so that each of its levels lasts at least two block-clock cycles at 50 MHz.

The configuration holding stage behaves like a pair of transparent latches. Its outputs follow the shift register while the serial strobe is high. They follow the parallel pins while the parallel strobe is low. They keep the last value they followed when the active strobe closes.

Top module: `pll_cfg_latch`

## Requirements
- R1: After reset, and before any load, the outputs are divider = 9'h1FF, output select = 2'b11 and test select = 3'b000. These are the values that undriven pins would give.
- R2: Each rising edge of the serial clock shifts the serial data bit into a 14-bit shift register. A frame is sent first bit first as test[2:0], then output select[1:0], then divider[8:0] with divider[8] before divider[0]. The last bit sent ends up in divider[0].
- R3: While the serial strobe is high and the parallel strobe is high, all three outputs follow the shift register.
- R4: When the serial strobe falls, the outputs hold the value they had at that transition.
- R5: While the parallel strobe is low, the divider and output select outputs follow the parallel pins. When the strobe rises, they hold the value they had at that transition, and later pin changes have no effect.
- R6: A parallel load never changes the test select output.
- R7: While neither strobe is active, serial shifting and changes on the parallel pins leave every output unchanged.
- R8: While both strobes are active, the divider and output select come from the parallel pins and the test select comes from the shift register.
- R9: Any change at the inputs reaches the outputs no later than 4 block-clock cycles after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk_i | input | 1 | Serial shift clock, at most 10 MHz |
| ser_dat_i | input | 1 | Serial data |
| ser_ld_i | input | 1 | Serial load strobe, active high |
| par_ld_ni | input | 1 | Parallel load strobe, active low |
| par_div_i | input | 9 | Parallel feedback divider value |
| par_osel_i | input | 2 | Parallel output divider select |
| div_o | output | 9 | Held feedback divider value |
| osel_o | output | 2 | Held output divider select |
| tsel_o | output | 3 | Held test-output select |

## Verification
A shift register that drops or doubles a bit shows up as a rotated or shifted field in the outputs. This becomes visible a few cycles after the next serial strobe opens. A holding stage that does not respect the strobe levels or the priority between them leaks pin or shift activity into the outputs. Such a leak is seen within 4 cycles of the stimulus. The bench compares the outputs 8 cycles after every step against values built from the frame layout, so either kind of fault is caught at the step that exposes it.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  parameter int unsigned DIV_W  = 9;
  parameter int unsigned OSEL_W = 2;
  parameter int unsigned TSEL_W = 3;
  localparam int unsigned FRAME_W = DIV_W + OSEL_W + TSEL_W;

  // Field order matches the serial frame: test select first, divider last.
  typedef struct packed {
    logic [TSEL_W-1:0] tsel;
    logic [OSEL_W-1:0] osel;
    logic [DIV_W-1:0]  div;
  } cfg_t;

  localparam cfg_t CFG_RST = '{tsel: '0, osel: '1, div: '1};
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST[g];
        sync_q <= RST[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
  import cfg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdat_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic               sclk_q;
  logic               rise;
  logic [FRAME_W-1:0] sreg_q, sreg_d;

  assign rise = sclk_i & ~sclk_q;

  always_comb begin
    sreg_d = sreg_q;
    if (rise) sreg_d = {sreg_q[FRAME_W-2:0], sdat_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sreg_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      sreg_q <= sreg_d;
    end
  end

  assign frame_o = sreg_q;

  // R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && !sclk_q) |=> sreg_q == {$past(sreg_q[FRAME_W-2:0]), $past(sdat_i)});

  // R7
  shift_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_i && !sclk_q) |=> $stable(sreg_q));
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
  import cfg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_ser_i,
  input  logic               ld_par_ni,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [DIV_W-1:0]   pdiv_i,
  input  logic [OSEL_W-1:0]  posel_i,
  output cfg_t               cfg_o
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (ld_ser_i) cfg_d = cfg_t'(frame_i);
    if (!ld_par_ni) begin
      cfg_d.div  = pdiv_i;
      cfg_d.osel = posel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  // R4
  hold_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_ser_i && ld_par_ni) |=> $stable(cfg_q));

  // R3
  ser_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ser_i && ld_par_ni) |=> cfg_q == $past(frame_i));

  // R8
  par_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_par_ni |=> (cfg_q.div == $past(pdiv_i)) && (cfg_q.osel == $past(posel_i)));

  // R6
  par_keeps_tsel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_par_ni && !ld_ser_i) |=> $stable(cfg_q.tsel));
endmodule

// File: rtl/pll_cfg_latch.sv
module pll_cfg_latch
  import cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_ld_i,
  input  logic              par_ld_ni,
  input  logic [DIV_W-1:0]  par_div_i,
  input  logic [OSEL_W-1:0] par_osel_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [OSEL_W-1:0] osel_o,
  output logic [TSEL_W-1:0] tsel_o
);
  localparam int unsigned PAR_W = 1 + DIV_W + OSEL_W;

  logic               rst_n_s;
  logic [2:0]         ser_s;
  logic [PAR_W-1:0]   par_s;
  logic [FRAME_W-1:0] frame;
  cfg_t               cfg;

  cfg_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n_s));

  cfg_sync #(.W(3), .RST(3'b000)) u_ser_sync (
    .clk_i(clk_i), .rst_ni(rst_n_s),
    .d_i({ser_ld_i, ser_dat_i, ser_clk_i}), .q_o(ser_s));

  cfg_sync #(.W(PAR_W), .RST({PAR_W{1'b1}})) u_par_sync (
    .clk_i(clk_i), .rst_ni(rst_n_s),
    .d_i({par_ld_ni, par_osel_i, par_div_i}), .q_o(par_s));

  cfg_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_n_s),
    .sclk_i(ser_s[0]), .sdat_i(ser_s[1]), .frame_o(frame));

  cfg_hold u_hold (
    .clk_i(clk_i), .rst_ni(rst_n_s),
    .ld_ser_i(ser_s[2]), .ld_par_ni(par_s[PAR_W-1]),
    .frame_i(frame),
    .pdiv_i(par_s[DIV_W-1:0]), .posel_i(par_s[DIV_W +: OSEL_W]),
    .cfg_o(cfg));

  assign div_o  = cfg.div;
  assign osel_o = cfg.osel;
  assign tsel_o = cfg.tsel;
endmodule

// File: tb/pll_cfg_latch_bench.sv
module pll_cfg_latch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, sdat = 1'b0, sld = 1'b0, pld_n = 1'b1;
  logic [8:0] pdiv = 9'h1FF;
  logic [1:0] posel = 2'b11;
  logic [8:0] div;
  logic [1:0] osel;
  logic [2:0] tsel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [8:0] div;
    logic [1:0] osel;
    logic [2:0] tsel;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  pll_cfg_latch u_pll_cfg_latch (
    .clk_i(clk), .rst_ni(rst_n),
    .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_ld_i(sld),
    .par_ld_ni(pld_n), .par_div_i(pdiv), .par_osel_i(posel),
    .div_o(div), .osel_o(osel), .tsel_o(tsel));

  task automatic expect_cfg(input logic [8:0] d, input logic [1:0] o,
                            input logic [2:0] t, input string req);
    exp_t e;
    e.div = d; e.osel = o; e.tsel = t; e.req = req;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic shift_frame(input logic [2:0] t, input logic [1:0] o,
                             input logic [8:0] d);
    logic [13:0] f;
    f = {t, o, d};
    for (int i = 13; i >= 0; i--) begin
      @(negedge clk); sdat = f[i];
      repeat (3) @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  // Monitor: results are compared 8 cycles after each expectation (R9 bound is 4).
  initial begin
    forever begin
      exp_t e;
      wait (sb_q.size() > 0);
      repeat (8) @(negedge clk);
      e = sb_q[0];
      checks++;
      if (div !== e.div || osel !== e.osel || tsel !== e.tsel) begin
        errors++;
        $display("FAIL %s: got div=%h osel=%b tsel=%b expected div=%h osel=%b tsel=%b",
                 e.req, div, osel, tsel, e.div, e.osel, e.tsel);
      end
      void'(sb_q.pop_front());
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_cfg(9'h1FF, 2'b11, 3'b000, "R1 reset state");

    // Frame shifted with the serial strobe low: no output change (R7)
    shift_frame(3'b101, 2'b01, 9'h0A5);
    expect_cfg(9'h1FF, 2'b11, 3'b000, "R7 shift while closed");
    pdiv = 9'h033; posel = 2'b00;
    expect_cfg(9'h1FF, 2'b11, 3'b000, "R7 pins while closed");

    // Serial strobe opens: outputs follow the shift register (R2, R3)
    sld = 1'b1;
    expect_cfg(9'h0A5, 2'b01, 3'b101, "R2 frame order");
    shift_frame(3'b010, 2'b10, 9'h15A);
    expect_cfg(9'h15A, 2'b10, 3'b010, "R3 follow while open");
    sld = 1'b0;
    expect_cfg(9'h15A, 2'b10, 3'b010, "R4 hold at fall");
    shift_frame(3'b111, 2'b11, 9'h100);
    expect_cfg(9'h15A, 2'b10, 3'b010, "R4 hold after fall");
    sld = 1'b1;
    expect_cfg(9'h100, 2'b11, 3'b111, "R2 msb of divider");
    sld = 1'b0;
    shift_frame(3'b000, 2'b00, 9'h001);
    sld = 1'b1; @(negedge clk); sld = 1'b0;
    expect_cfg(9'h001, 2'b00, 3'b000, "R2 last bit to div0");

    // Parallel path (R5, R6)
    pdiv = 9'h123; posel = 2'b10; pld_n = 1'b0;
    expect_cfg(9'h123, 2'b10, 3'b000, "R5 follow pins");
    pdiv = 9'h0F0; posel = 2'b01;
    expect_cfg(9'h0F0, 2'b01, 3'b000, "R5 follow pin change");
    pld_n = 1'b1;
    expect_cfg(9'h0F0, 2'b01, 3'b000, "R5 hold at rise");
    pdiv = 9'h1AA; posel = 2'b11;
    expect_cfg(9'h0F0, 2'b01, 3'b000, "R5 pins ignored after rise");

    // Test select kept by a parallel load (R6)
    shift_frame(3'b110, 2'b00, 9'h055);
    sld = 1'b1; @(negedge clk); sld = 1'b0;
    expect_cfg(9'h055, 2'b00, 3'b110, "R2 load before R6");
    pdiv = 9'h0C3; posel = 2'b10; pld_n = 1'b0;
    @(negedge clk); pld_n = 1'b1;
    expect_cfg(9'h0C3, 2'b10, 3'b110, "R6 tsel kept");

    // Both strobes active (R8)
    pdiv = 9'h077; posel = 2'b01; pld_n = 1'b0; sld = 1'b1;
    expect_cfg(9'h077, 2'b01, 3'b110, "R8 parallel priority");
    shift_frame(3'b011, 2'b10, 9'h1E1);
    expect_cfg(9'h077, 2'b01, 3'b011, "R8 tsel from serial");
    pld_n = 1'b1; sld = 1'b0;
    expect_cfg(9'h077, 2'b01, 3'b011, "R8 hold after both close");

    // Latency bound (R9): a parallel change visible 4 cycles later
    pdiv = 9'h10F; posel = 2'b00; pld_n = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (div !== 9'h10F || osel !== 2'b00) begin
      errors++;
      $display("FAIL R9 latency: got div=%h osel=%b expected div=10f osel=00", div, osel);
    end
    pld_n = 1'b1;
    repeat (4) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule